// File: doc/BRIEF.md
# Cache-Line Merge Selector

This block sits behind a small buffer of pending loads or stores and gathers the requests that fall into one cache line, so that a single line access can serve all of them. Each of the eight buffer entries offers a full line of data (128 bits) and a 16-bit byte-enable mask. A square match array arrives alongside them. Row i of that array marks every entry that targets the same line as entry i, and a live entry always marks itself.

The block is purely combinational. It takes the lowest-numbered row that has any bit set. It then combines, through balanced OR trees, the data and the byte enables of every entry flagged in that row. The result is one line-wide record whose enables can drive the byte lanes of a cache line directly.

The block also reports whether any row was picked, and which one. Upstream logic uses that index to retire the merged entries. Within one batch, the entries merged together never share an enabled byte, so OR-combining their data loses nothing.

Top module: `line_merge_sel`

## Requirements
- R1: When no bit of `match_i` is set, `line_data_o` and `line_ben_o` are all zero, `hit_o` is 0 and `pick_idx_o` is 0.
- R2: Row r of the match array is bits `match_i[r*8 +: 8]`. Bit j of that row flags entry j. A row is active when any of its bits is set. `hit_o` is 1 when some row is active, and `pick_idx_o` is then the lowest index of an active row.
- R3: The byte enables of entry k are `ent_ben_i[k*16 +: 16]`, with bit b enabling byte b of the line. `line_ben_o` is the bitwise OR of the enables of every entry flagged in the picked row.
- R4: The data of entry k is `ent_data_i[k*128 +: 128]`. `line_data_o` is the bitwise OR of the data of every entry flagged in the picked row.
- R5: The contents of active rows above the picked row have no effect on any output.
- R6: The data and enables of entries that are not flagged in the picked row have no effect on `line_data_o` or `line_ben_o`.
- R7: When the picked row flags only its own entry, that entry's data and enables appear unchanged on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ent_data_i | input | 1024 | Line data of the 8 entries, entry k at bits k*128 upward |
| ent_ben_i | input | 128 | Byte enables of the 8 entries, entry k at bits k*16 upward |
| match_i | input | 64 | Same-line match array, row r at bits r*8 upward |
| line_data_o | output | 128 | Merged line data |
| line_ben_o | output | 16 | Merged byte enables |
| hit_o | output | 1 | A row was picked |
| pick_idx_o | output | 3 | Index of the picked row |

## Verification
The in-line assertions cover the following on every evaluation:
- the pick is one-hot and lands on an active row with no active row below it;
- an idle array gives zero outputs;
- the merged enables cover every flagged entry's enables and contain nothing outside the union of all entries;
- the merged data stays inside the union of all entry data.

Some behaviour is shown only by the bench's behavioural model compared on every clock. Exact equality of the merged data and enables is one part of it. The rest is the proof that rows above the pick and unflagged entries leave the outputs untouched. The directed patterns for the single-entry and full-line cases are also bench-only.

// File: rtl/line_merge_pkg.sv
package line_merge_pkg;
  localparam int unsigned LM_ENTRIES    = 8;
  localparam int unsigned LM_LINE_BYTES = 16;

  // next power of two at or above n, used to pad the reduction trees
  function automatic int unsigned lm_pow2_ceil(input int unsigned n);
    int unsigned p;
    p = 1;
    while (p < n) p = p * 2;
    return p;
  endfunction

  // number of halving levels from a padded width down to one node
  function automatic int unsigned lm_levels(input int unsigned n);
    int unsigned p;
    int unsigned l;
    p = lm_pow2_ceil(n);
    l = 0;
    while (p > 1) begin
      p = p / 2;
      l = l + 1;
    end
    return l;
  endfunction
endpackage

// File: rtl/lm_row_pick.sv
module lm_row_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N*N-1:0] match_i,
  output logic [N-1:0]   row_active_o,
  output logic [N-1:0]   pick_oh_o,
  output logic [N-1:0]   sel_row_o,
  output logic [IW-1:0]  pick_idx_o,
  output logic           hit_o
);
  // isolate the lowest set bit of a vector
  function automatic logic [N-1:0] lowest_one(input logic [N-1:0] v);
    return v & (~v + {{(N-1){1'b0}}, 1'b1});
  endfunction

  // binary index of a one-hot vector
  function automatic logic [IW-1:0] oh_index(input logic [N-1:0] oh);
    logic [IW-1:0] idx;
    idx = '0;
    for (int k = 0; k < N; k++) begin
      if (oh[k]) idx = idx | IW'(k);
    end
    return idx;
  endfunction

  for (genvar r = 0; r < N; r++) begin : g_row
    assign row_active_o[r] = |match_i[r*N +: N];
  end

  assign pick_oh_o  = lowest_one(row_active_o);
  assign pick_idx_o = oh_index(pick_oh_o);
  assign hit_o      = |pick_oh_o;

  // and-or mux of the picked row
  always_comb begin
    sel_row_o = '0;
    for (int r = 0; r < N; r++) begin
      if (pick_oh_o[r]) sel_row_o = sel_row_o | match_i[r*N +: N];
    end
  end

  always_comb begin
    logic lower_active;
    lower_active = 1'b0;
    for (int r = 0; r < N; r++) begin
      if (r < int'(pick_idx_o) && row_active_o[r]) lower_active = 1'b1;
    end
    if (!$isunknown(match_i)) begin
      p_pick_onehot_r2: assert ($onehot0(pick_oh_o));
      p_hit_iff_active_r2: assert (hit_o == (row_active_o != '0));
      p_picked_is_active_r2: assert (!hit_o || row_active_o[pick_idx_o]);
      p_nothing_below_r2: assert (!hit_o || !lower_active);
    end
  end
endmodule

// File: rtl/lm_or_tree.sv
module lm_or_tree
  import line_merge_pkg::*;
#(
  parameter int unsigned N = 8,
  parameter int unsigned W = 16
) (
  input  logic [N*W-1:0] leaves_i,
  output logic [W-1:0]   root_o
);
  localparam int unsigned P  = lm_pow2_ceil(N);
  localparam int unsigned LV = lm_levels(N);

  for (genvar l = 0; l <= LV; l++) begin : g_lv
    localparam int unsigned CNT = P >> l;
    logic [W-1:0] v [CNT];
    if (l == 0) begin : g_leaf
      for (genvar k = 0; k < CNT; k++) begin : g_k
        if (k < N) begin : g_real
          assign v[k] = leaves_i[k*W +: W];
        end else begin : g_pad
          assign v[k] = '0;
        end
      end
    end else begin : g_node
      for (genvar k = 0; k < CNT; k++) begin : g_k
        assign v[k] = g_lv[l-1].v[2*k] | g_lv[l-1].v[2*k+1];
      end
    end
  end

  assign root_o = g_lv[LV].v[0];
endmodule

// File: rtl/line_merge_sel.sv
module line_merge_sel
  import line_merge_pkg::*;
#(
  parameter int unsigned N_ENT      = LM_ENTRIES,
  parameter int unsigned LINE_BYTES = LM_LINE_BYTES,
  parameter int unsigned DATA_W     = LINE_BYTES * 8,
  parameter int unsigned IDX_W      = $clog2(N_ENT)
) (
  input  logic [N_ENT*DATA_W-1:0]     ent_data_i,
  input  logic [N_ENT*LINE_BYTES-1:0] ent_ben_i,
  input  logic [N_ENT*N_ENT-1:0]      match_i,
  output logic [DATA_W-1:0]           line_data_o,
  output logic [LINE_BYTES-1:0]       line_ben_o,
  output logic                        hit_o,
  output logic [IDX_W-1:0]            pick_idx_o
);
  logic [N_ENT-1:0] row_active;
  logic [N_ENT-1:0] pick_oh;
  logic [N_ENT-1:0] sel_row;

  logic [N_ENT*DATA_W-1:0]     gated_data;
  logic [N_ENT*LINE_BYTES-1:0] gated_ben;

  lm_row_pick #(.N(N_ENT), .IW(IDX_W)) u_pick (
    .match_i      (match_i),
    .row_active_o (row_active),
    .pick_oh_o    (pick_oh),
    .sel_row_o    (sel_row),
    .pick_idx_o   (pick_idx_o),
    .hit_o        (hit_o)
  );

  // each entry contributes only when flagged in the picked row
  for (genvar k = 0; k < N_ENT; k++) begin : g_gate
    assign gated_data[k*DATA_W +: DATA_W] =
      sel_row[k] ? ent_data_i[k*DATA_W +: DATA_W] : '0;
    assign gated_ben[k*LINE_BYTES +: LINE_BYTES] =
      sel_row[k] ? ent_ben_i[k*LINE_BYTES +: LINE_BYTES] : '0;
  end

  lm_or_tree #(.N(N_ENT), .W(DATA_W)) u_data_tree (
    .leaves_i (gated_data),
    .root_o   (line_data_o)
  );

  lm_or_tree #(.N(N_ENT), .W(LINE_BYTES)) u_ben_tree (
    .leaves_i (gated_ben),
    .root_o   (line_ben_o)
  );

  always_comb begin
    logic [DATA_W-1:0]     all_data;
    logic [LINE_BYTES-1:0] all_ben;
    logic                  miss_cover;
    all_data   = '0;
    all_ben    = '0;
    miss_cover = 1'b0;
    for (int k = 0; k < N_ENT; k++) begin
      all_data = all_data | ent_data_i[k*DATA_W +: DATA_W];
      all_ben  = all_ben  | ent_ben_i[k*LINE_BYTES +: LINE_BYTES];
      if (hit_o && match_i[int'(pick_idx_o)*N_ENT + k] &&
          ((ent_ben_i[k*LINE_BYTES +: LINE_BYTES] & ~line_ben_o) != '0))
        miss_cover = 1'b1;
    end
    if (!$isunknown({match_i, ent_ben_i, ent_data_i})) begin
      p_idle_zero_r1: assert (hit_o || (line_ben_o == '0 && line_data_o == '0));
      p_ben_in_union_r3: assert ((line_ben_o & ~all_ben) == '0);
      p_flagged_covered_r3: assert (!miss_cover);
      p_data_in_union_r4: assert ((line_data_o & ~all_data) == '0);
    end
  end
endmodule

// File: tb/line_merge_sel_bench.sv
module line_merge_sel_bench;
  localparam int CLK_P = 10;
  localparam int NE    = 8;
  localparam int NB    = 16;
  localparam int DW    = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic [DW-1:0] d [NE];
  logic [NB-1:0] b [NE];
  logic [NE-1:0] m [NE];

  logic [NE*DW-1:0] ent_data;
  logic [NE*NB-1:0] ent_ben;
  logic [NE*NE-1:0] match;
  logic [DW-1:0]    line_data;
  logic [NB-1:0]    line_ben;
  logic             hit;
  logic [2:0]       pick_idx;

  always_comb begin
    for (int k = 0; k < NE; k++) begin
      ent_data[k*DW +: DW] = d[k];
      ent_ben[k*NB +: NB]  = b[k];
      match[k*NE +: NE]    = m[k];
    end
  end

  line_merge_sel u_line_merge_sel (
    .ent_data_i  (ent_data),
    .ent_ben_i   (ent_ben),
    .match_i     (match),
    .line_data_o (line_data),
    .line_ben_o  (line_ben),
    .hit_o       (hit),
    .pick_idx_o  (pick_idx)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_all();
    for (int k = 0; k < NE; k++) begin
      d[k] = '0; b[k] = '0; m[k] = '0;
    end
  endtask

  // behavioural reference: scan rows, then fold flagged entries
  task automatic compare(input string req);
    int row;
    logic [DW-1:0] ed;
    logic [NB-1:0] eb;
    row = -1; ed = '0; eb = '0;
    for (int r = NE - 1; r >= 0; r--) if (m[r] != 0) row = r;
    if (row >= 0)
      for (int j = 0; j < NE; j++)
        if (m[row][j]) begin ed |= d[j]; eb |= b[j]; end
    chk(req, "hit", DW'(hit), DW'(row >= 0));
    chk(req, "pick_idx", DW'(pick_idx), DW'((row >= 0) ? row : 0));
    chk(req, "ben", DW'(line_ben), DW'(eb));
    chk(req, "data", line_data, ed);
  endtask

  task automatic step(input string req);
    @(posedge clk);
    @(negedge clk);
    compare(req);
  endtask

  task automatic random_fill();
    for (int k = 0; k < NE; k++) begin
      d[k] = {$urandom, $urandom, $urandom, $urandom};
      b[k] = '0;
      if ($urandom % 3 == 0) m[k] = '0;
      else m[k] = 8'($urandom) | (8'd1 << k);
    end
    // each byte has at most one owner, so enables never overlap
    for (int by = 0; by < NB; by++) begin
      int o;
      o = $urandom % (NE + 2);
      if (o < NE) b[o][by] = 1'b1;
    end
    if ($urandom % 16 == 0) for (int k = 0; k < NE; k++) m[k] = '0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clear_all();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset/idle state, all zero
    chk("R1", "idle hit", DW'(hit), '0);
    chk("R1", "idle idx", DW'(pick_idx), '0);
    chk("R1", "idle ben", DW'(line_ben), '0);
    chk("R1", "idle data", line_data, '0);

    // R1: entries carry data but no row active
    for (int k = 0; k < NE; k++) begin d[k] = '1; b[k] = '1; end
    step("R1");

    // R7: only the diagonal of row 3
    clear_all();
    d[3] = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
    b[3] = 16'h0f0f;
    d[4] = '1; b[4] = 16'hf0f0;
    m[3] = 8'h08;
    step("R7");
    chk("R7", "pass ben", DW'(line_ben), DW'(16'h0f0f));
    chk("R7", "pass data", line_data, 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210);

    // R2, R5: rows 2 and 5 active, row 5 flags different entries
    clear_all();
    d[1] = 128'hff; b[1] = 16'h0001;
    d[2] = 128'hff00; b[2] = 16'h0002;
    d[6] = 128'hff0000; b[6] = 16'h0004;
    d[5] = 128'hff000000; b[5] = 16'h0008;
    m[2] = 8'b0000_0110;
    m[5] = 8'b0110_0000;
    step("R5");
    chk("R2", "lowest row", DW'(pick_idx), DW'(2));
    chk("R5", "upper row ignored ben", DW'(line_ben), DW'(16'h0003));

    // R6: unflagged entries full of ones, flagged pair merges
    clear_all();
    for (int k = 0; k < NE; k++) begin d[k] = '1; b[k] = '1; end
    d[0] = 128'h1; b[0] = 16'h0001;
    d[7] = 128'h2; b[7] = 16'h8000;
    m[0] = 8'b1000_0001;
    step("R6");
    chk("R6", "unflagged data", line_data, 128'h3);
    chk("R3", "two-entry ben", DW'(line_ben), DW'(16'h8001));

    // R3, R4: full line from all eight entries, two bytes each
    clear_all();
    for (int k = 0; k < NE; k++) begin
      b[k] = 16'(16'h3 << (2 * k));
      d[k] = DW'(16'hbeef) << (16 * k);
      m[k] = '1;
    end
    step("R3");
    chk("R3", "full line ben", DW'(line_ben), DW'(16'hffff));
    chk("R4", "full line data", line_data, {8{16'hbeef}});

    // R2: only the last row active
    clear_all();
    d[7] = 128'h55; b[7] = 16'h0010; m[7] = 8'h81;
    d[0] = 128'haa00; b[0] = 16'h0100;
    step("R2");
    chk("R2", "last row idx", DW'(pick_idx), DW'(7));

    // R2, R3, R4: random batches compared every clock
    for (int i = 0; i < 400; i++) begin
      random_fill();
      step("R4");
    end

    clear_all();
    step("R1");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule